// File: doc/BRIEF.md
# PMIC register bank with interrupts

This block is the register file of a power-management companion chip. It sits behind the parallel side of a three-wire serial bus target: once the target has shifted in a device address, a read/write flag, a 5-bit register number and (for writes) a 16-bit value, it presents them here as a one-cycle access strobe. A write takes effect at that clock edge. A read loads the addressed register into a read-data register, and the target shifts that value back out.

The bank holds a fixed identity word and a pending/mask interrupt pair that drives a level interrupt. It also holds an ADC channel select whose conversion result arrives on an input port, a sample-control register that software clears bit by bit, and two general control registers. Further registers are an RTC calibration word, a status word that follows a power-key input, and a watchdog register. A zero write to the watchdog register requests system shutdown when enabled. Registers of functions that are not built (RTC counting, audio, regulators) read as zero and ignore writes. Reserved addresses flag an error, and accesses aimed at another device number are ignored.

Top module: `pmic_regbank`

## Requirements
- R1: A read of register 0x00 returns 0x0215, with bit 7 also set while `variant_i` is high. Writes to 0x00 change nothing.
- R2: After reset the registers read as follows: mask (0x02) 0xFFFF, pending (0x01) 0x0000, status (0x16) 0x0020, calibration (0x06) 0x0001, sample control (0x09) 0x00FF, control registers 0x0D and 0x0E 0x0000, ADC channel 0. The outputs `irq_o`, `shutdown_o` and `acc_err_o` are low.
- R3: A read of 0x01 returns the 16 pending bits. A write to 0x01 XORs the written value into them.
- R4: Register 0x02 is a read/write mask in which a 1 disables a source. `irq_o` is high exactly when some pending bit is 1 and its mask bit is 0, and it follows each pending or mask change in the cycle after that change's clock edge.
- R5: A read of 0x08 returns the selected channel in bits [13:10] and `adc_data_i` in bits [9:0], with bits [15:14] zero. A write to 0x08 loads the channel from bits [13:10] of the written value, drives it on `adc_chan_o`, and sets pending bit 8.
- R6: A write to 0x09 clears every sample-control bit for which the written value holds a 1, and leaves the other bits unchanged.
- R7: A write of 0x0000 to 0x17 raises `shutdown_o` only while bit 1 of register 0x0D is 1. Nonzero writes have no effect. Once `shutdown_o` is high it stays high until reset. Register 0x17 reads as zero.
- R8: Each change of `pwr_key_i` (1 = pressed) sets pending bit 0 once, in the clock after the change. Status bit 5 is 0 while the key is pressed and 1 while it is released. A key held steady does not set pending bit 0 again.
- R9: Registers 0x06, 0x0D and 0x0E store and return any 16-bit value written to them.
- R10: An access to 0x07 or to 0x12 through 0x15 pulses `acc_err_o` for one cycle, changes no register, and a read of such an address returns 0.
- R11: An access whose device address differs from `DEV_ADDR` (default 1) changes no register, does not raise `acc_err_o`, and leaves `acc_rdata_o` unchanged.
- R12: Registers 0x03–0x05, 0x0A–0x0C, 0x0F–0x11 and 0x18–0x1F read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| variant_i | input | 1 | Variant strap; sets bit 7 of the identity word |
| pwr_key_i | input | 1 | Power key level, 1 = pressed |
| adc_data_i | input | 10 | Conversion result for the channel on `adc_chan_o` |
| acc_valid_i | input | 1 | One-cycle access strobe from the bus target |
| acc_dev_i | input | 3 | Decoded device address |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_reg_i | input | 5 | Register number |
| acc_wdata_i | input | 16 | Write value |
| acc_rdata_o | output | 16 | Read data, loaded at the edge of a read strobe |
| acc_err_o | output | 1 | One-cycle pulse after an access to a reserved address |
| adc_chan_o | output | 4 | Selected ADC channel |
| irq_o | output | 1 | Level interrupt: pending AND NOT mask |
| shutdown_o | output | 1 | Sticky shutdown request |

## Verification
The hardest case to reach is a power-key edge that lands on the same clock as a software write to the pending register. That write would otherwise XOR away the bit the key sets. Random writes of random values would also soon drop `shutdown_o` into its sticky state and hide every later watchdog case. To avoid that, the stimulus toggles the key between bus accesses, and the directed part aims key edges at chosen moments. The watchdog sequence runs in order: first a gated-off zero write, then an enabled nonzero write, and only then the enabled zero write. The random phase draws zero write values often, so the watchdog enable and the zero value meet by chance as well.

// File: rtl/pmic_pkg.sv
package pmic_pkg;

  localparam int REG_AW = 5;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_ID, SEL_PEND, SEL_MASK, SEL_CAL, SEL_ADC,
    SEL_SAMP, SEL_CC1, SEL_CC2, SEL_STAT, SEL_WDOG, SEL_BAD
  } reg_sel_e;

  // Register number to function; unlisted numbers are zero-reading stubs.
  function automatic reg_sel_e map_reg(input logic [REG_AW-1:0] a);
    reg_sel_e s;
    case (a)
      5'h00:   s = SEL_ID;
      5'h01:   s = SEL_PEND;
      5'h02:   s = SEL_MASK;
      5'h06:   s = SEL_CAL;
      5'h08:   s = SEL_ADC;
      5'h09:   s = SEL_SAMP;
      5'h0D:   s = SEL_CC1;
      5'h0E:   s = SEL_CC2;
      5'h16:   s = SEL_STAT;
      5'h17:   s = SEL_WDOG;
      5'h07, 5'h12, 5'h13, 5'h14, 5'h15: s = SEL_BAD;
      default: s = SEL_ZERO;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pmic_decode.sv
module pmic_decode
  import pmic_pkg::*;
#(
  parameter int DEV_W    = 3,
  parameter int DEV_ADDR = 1
) (
  input  logic              valid_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic              write_i,
  input  logic [REG_AW-1:0] reg_i,
  output logic              wr_stb_o,
  output logic              rd_stb_o,
  output logic              bad_o,
  output reg_sel_e          sel_o
);

  logic hit;

  always_comb begin
    hit      = valid_i && (dev_i == DEV_W'(DEV_ADDR));
    sel_o    = map_reg(reg_i);
    bad_o    = hit && (sel_o == SEL_BAD);
    wr_stb_o = hit && write_i  && (sel_o != SEL_BAD);
    rd_stb_o = hit && !write_i;
  end

endmodule

// File: rtl/pmic_irq_ctrl.sv
module pmic_irq_ctrl #(
  parameter int N       = 16,
  parameter int ADC_BIT = 8,
  parameter int KEY_BIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pend_wr_i,
  input  logic         mask_wr_i,
  input  logic [N-1:0] wdata_i,
  input  logic         adc_evt_i,
  input  logic         key_evt_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);

  logic [N-1:0] pend_q, pend_d, mask_q, mask_d;
  logic         pend_en;

  always_comb begin
    pend_en = pend_wr_i || adc_evt_i || key_evt_i;
    pend_d  = pend_q;
    if (pend_wr_i) pend_d = pend_q ^ wdata_i;
    // Hardware events are applied last so a same-cycle toggle cannot lose them.
    if (adc_evt_i) pend_d[ADC_BIT] = 1'b1;
    if (key_evt_i) pend_d[KEY_BIT] = 1'b1;
    mask_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
    end else begin
      if (pend_en)   pend_q <= pend_d;
      if (mask_wr_i) mask_q <= mask_d;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq_o  = |(pend_q & ~mask_q);

endmodule

// File: rtl/pmic_key_status.sv
module pmic_key_status #(
  parameter int          W        = 16,
  parameter logic [15:0] STAT_RST = 16'h0020,
  parameter int          REL_BIT  = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         key_i,
  output logic         key_evt_o,
  output logic [W-1:0] status_o
);

  logic         key_q;
  logic [W-1:0] stat_q, stat_d;

  always_comb begin
    key_evt_o       = key_i ^ key_q;
    stat_d          = stat_q;
    stat_d[REL_BIT] = ~key_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q  <= 1'b0;
      stat_q <= W'(STAT_RST);
    end else begin
      key_q <= key_i;
      if (key_evt_o) stat_q <= stat_d;
    end
  end

  assign status_o = stat_q;

endmodule

// File: rtl/pmic_regbank.sv
module pmic_regbank
  import pmic_pkg::*;
#(
  parameter int          DEV_W      = 3,
  parameter int          DEV_ADDR   = 1,
  parameter int          DATA_W     = 16,
  parameter int          ADC_W      = 10,
  parameter int          CHAN_W     = 4,
  parameter logic [15:0] ID_WORD    = 16'h0215,
  parameter int          VAR_BIT    = 7,
  parameter logic [15:0] CAL_RST    = 16'h0001,
  parameter logic [15:0] SAMP_RST   = 16'h00FF,
  parameter logic [15:0] STAT_RST   = 16'h0020,
  parameter int          WDOG_EN    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              variant_i,
  input  logic              pwr_key_i,
  input  logic [ADC_W-1:0]  adc_data_i,
  input  logic              acc_valid_i,
  input  logic [DEV_W-1:0]  acc_dev_i,
  input  logic              acc_write_i,
  input  logic [REG_AW-1:0] acc_reg_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  output logic              acc_err_o,
  output logic [CHAN_W-1:0] adc_chan_o,
  output logic              irq_o,
  output logic              shutdown_o
);

  localparam int PAD_W   = DATA_W - CHAN_W - ADC_W;
  localparam int ADC_BIT = 8;
  localparam int KEY_BIT = 0;
  localparam int REL_BIT = 5;

  // Reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Access decode
  logic     wr_stb, rd_stb, bad;
  reg_sel_e sel;

  pmic_decode #(.DEV_W(DEV_W), .DEV_ADDR(DEV_ADDR)) u_dec (
    .valid_i (acc_valid_i),
    .dev_i   (acc_dev_i),
    .write_i (acc_write_i),
    .reg_i   (acc_reg_i),
    .wr_stb_o(wr_stb),
    .rd_stb_o(rd_stb),
    .bad_o   (bad),
    .sel_o   (sel)
  );

  // Power key and status
  logic              key_evt;
  logic [DATA_W-1:0] status;

  pmic_key_status #(.W(DATA_W), .STAT_RST(STAT_RST), .REL_BIT(REL_BIT)) u_key (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .key_i    (pwr_key_i),
    .key_evt_o(key_evt),
    .status_o (status)
  );

  // Interrupt pending / mask
  logic [DATA_W-1:0] pend_q, mask_q;
  logic              pend_wr, mask_wr, adc_wr;

  assign pend_wr = wr_stb && (sel == SEL_PEND);
  assign mask_wr = wr_stb && (sel == SEL_MASK);
  assign adc_wr  = wr_stb && (sel == SEL_ADC);

  pmic_irq_ctrl #(.N(DATA_W), .ADC_BIT(ADC_BIT), .KEY_BIT(KEY_BIT)) u_irq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pend_wr_i(pend_wr),
    .mask_wr_i(mask_wr),
    .wdata_i  (acc_wdata_i),
    .adc_evt_i(adc_wr),
    .key_evt_i(key_evt),
    .pend_o   (pend_q),
    .mask_o   (mask_q),
    .irq_o    (irq_o)
  );

  // Local registers
  logic [DATA_W-1:0] cal_q, samp_q, cc1_q, cc2_q, rdata_q;
  logic [DATA_W-1:0] samp_d, rdata_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic              shut_q, shut_set, err_q;
  logic              cal_en, samp_en, cc1_en, cc2_en;

  always_comb begin
    cal_en   = wr_stb && (sel == SEL_CAL);
    samp_en  = wr_stb && (sel == SEL_SAMP);
    cc1_en   = wr_stb && (sel == SEL_CC1);
    cc2_en   = wr_stb && (sel == SEL_CC2);
    samp_d   = samp_q & ~acc_wdata_i;
    chan_d   = acc_wdata_i[ADC_W +: CHAN_W];
    shut_set = wr_stb && (sel == SEL_WDOG) && (acc_wdata_i == '0) && cc1_q[WDOG_EN];
  end

  // Read multiplexer
  always_comb begin
    case (sel)
      SEL_ID: begin
        rdata_d          = DATA_W'(ID_WORD);
        rdata_d[VAR_BIT] = rdata_d[VAR_BIT] | variant_i;
      end
      SEL_PEND: rdata_d = pend_q;
      SEL_MASK: rdata_d = mask_q;
      SEL_CAL:  rdata_d = cal_q;
      SEL_ADC:  rdata_d = {{PAD_W{1'b0}}, chan_q, adc_data_i};
      SEL_SAMP: rdata_d = samp_q;
      SEL_CC1:  rdata_d = cc1_q;
      SEL_CC2:  rdata_d = cc2_q;
      SEL_STAT: rdata_d = status;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cal_q   <= DATA_W'(CAL_RST);
      samp_q  <= DATA_W'(SAMP_RST);
      cc1_q   <= '0;
      cc2_q   <= '0;
      chan_q  <= '0;
      shut_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (cal_en)   cal_q   <= acc_wdata_i;
      if (samp_en)  samp_q  <= samp_d;
      if (cc1_en)   cc1_q   <= acc_wdata_i;
      if (cc2_en)   cc2_q   <= acc_wdata_i;
      if (adc_wr)   chan_q  <= chan_d;
      if (shut_set) shut_q  <= 1'b1;
      if (rd_stb)   rdata_q <= rdata_d;
      err_q <= bad;
    end
  end

  assign acc_rdata_o = rdata_q;
  assign acc_err_o   = err_q;
  assign adc_chan_o  = chan_q;
  assign shutdown_o  = shut_q;

endmodule

// File: rtl/pmic_regbank_chk.sv
module pmic_regbank_chk #(
  parameter int DEV_W    = 3,
  parameter int DEV_ADDR = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid_i,
  input logic [DEV_W-1:0] acc_dev_i,
  input logic             acc_write_i,
  input logic [4:0]       acc_reg_i,
  input logic [15:0]      acc_wdata_i,
  input logic             acc_err_o,
  input logic             irq_o,
  input logic             shutdown_o,
  input logic             pwr_key_i,
  input logic             pend_adc,
  input logic             pend_key
);

  logic mine, reserved;
  assign mine     = acc_valid_i && (acc_dev_i == DEV_W'(DEV_ADDR));
  assign reserved = (acc_reg_i == 5'h07) || ((acc_reg_i >= 5'h12) && (acc_reg_i <= 5'h15));

  // R4: writing an all-ones mask silences the interrupt next cycle
  a_r4_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mine && acc_write_i && acc_reg_i == 5'h02 && acc_wdata_i == 16'hFFFF) |=> !irq_o);

  // R5: an ADC register write leaves the sample-done bit pending
  a_r5_adc_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (mine && acc_write_i && acc_reg_i == 5'h08) |=> pend_adc);

  // R7: shutdown request is sticky
  a_r7_shutdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |=> shutdown_o);

  // R7: shutdown only follows a zero write to the watchdog register
  a_r7_shutdown_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown_o) |-> $past(mine && acc_write_i && acc_reg_i == 5'h17 && acc_wdata_i == 16'h0000));

  // R8: a key press leaves pending bit 0 set
  a_r8_press_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_key_i) |=> pend_key);

  // R10: an error pulse only follows a reserved-address access
  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err_o |-> $past(mine && reserved));

  // R11: foreign device accesses never raise the error flag
  a_r11_foreign_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && acc_dev_i != DEV_W'(DEV_ADDR)) |=> !acc_err_o);

endmodule

bind pmic_regbank pmic_regbank_chk #(.DEV_W(DEV_W), .DEV_ADDR(DEV_ADDR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .acc_valid_i(acc_valid_i),
  .acc_dev_i  (acc_dev_i),
  .acc_write_i(acc_write_i),
  .acc_reg_i  (acc_reg_i),
  .acc_wdata_i(acc_wdata_i),
  .acc_err_o  (acc_err_o),
  .irq_o      (irq_o),
  .shutdown_o (shutdown_o),
  .pwr_key_i  (pwr_key_i),
  .pend_adc   (pend_q[ADC_BIT]),
  .pend_key   (pend_q[KEY_BIT])
);

// File: tb/tb_pmic_regbank.sv
`timescale 1ns/1ps
module tb_pmic_regbank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        variant;
  logic        pwr_key;
  logic [9:0]  adc_data;
  logic        acc_valid;
  logic [2:0]  acc_dev;
  logic        acc_write;
  logic [4:0]  acc_reg;
  logic [15:0] acc_wdata;
  logic [15:0] acc_rdata;
  logic        acc_err;
  logic [3:0]  adc_chan;
  logic        irq;
  logic        shutdown;

  always #10 clk = ~clk;

  pmic_regbank dut (
    .clk(clk), .rst_n(rst_n), .variant_i(variant), .pwr_key_i(pwr_key),
    .adc_data_i(adc_data), .acc_valid_i(acc_valid), .acc_dev_i(acc_dev),
    .acc_write_i(acc_write), .acc_reg_i(acc_reg), .acc_wdata_i(acc_wdata),
    .acc_rdata_o(acc_rdata), .acc_err_o(acc_err), .adc_chan_o(adc_chan),
    .irq_o(irq), .shutdown_o(shutdown)
  );

  // External converter model
  function automatic logic [9:0] adc_model(input logic [3:0] ch);
    return 10'((ch * 37 + 5) ^ 10'h2A5);
  endfunction
  assign adc_data = adc_model(adc_chan);

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic [15:0] m_pend, m_mask, m_cal, m_samp, m_cc1, m_cc2, m_stat;
  logic [3:0]  m_chan;
  logic        m_shut;
  logic [15:0] last_rd;
  logic        last_err;

  function automatic bit is_reserved(input logic [4:0] r);
    return (r == 5'h07) || (r >= 5'h12 && r <= 5'h15);
  endfunction

  function automatic logic [15:0] exp_read(input logic [4:0] r);
    case (r)
      5'h00: return 16'h0215 | (16'(variant) << 7);
      5'h01: return m_pend;
      5'h02: return m_mask;
      5'h06: return m_cal;
      5'h08: return {2'b00, m_chan, adc_model(m_chan)};
      5'h09: return m_samp;
      5'h0D: return m_cc1;
      5'h0E: return m_cc2;
      5'h16: return m_stat;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_write(input logic [4:0] r, input logic [15:0] d);
    case (r)
      5'h01: m_pend = m_pend ^ d;
      5'h02: m_mask = d;
      5'h06: m_cal  = d;
      5'h08: begin m_chan = d[13:10]; m_pend[8] = 1'b1; end
      5'h09: m_samp = m_samp & ~d;
      5'h0D: m_cc1  = d;
      5'h0E: m_cc2  = d;
      5'h17: if (d == 16'h0000 && m_cc1[1]) m_shut = 1'b1;
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_access(input logic [2:0] dv, input logic wr, input logic [4:0] r, input logic [15:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_dev = dv; acc_write = wr; acc_reg = r; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
    last_rd  = acc_rdata;
    last_err = acc_err;
  endtask

  task automatic wr_reg(input logic [4:0] r, input logic [15:0] d);
    bus_access(3'd1, 1'b1, r, d);
    model_write(r, d);
  endtask

  task automatic rd_check(input string req, input logic [4:0] r);
    bus_access(3'd1, 1'b0, r, 16'h0);
    check(req, last_rd, exp_read(r));
  endtask

  task automatic set_key(input logic v);
    @(negedge clk);
    pwr_key = v;
    @(negedge clk);
    if (m_stat[5] == v) begin
      m_pend[0] = 1'b1;
      m_stat[5] = ~v;
    end
  endtask

  task automatic check_irq(input string req);
    check(req, 16'(irq), 16'(|(m_pend & ~m_mask)));
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    rst_n = 1'b0; variant = 1'b0; pwr_key = 1'b0;
    acc_valid = 1'b0; acc_dev = 3'd0; acc_write = 1'b0; acc_reg = 5'd0; acc_wdata = 16'd0;
    m_pend = 16'h0000; m_mask = 16'hFFFF; m_cal = 16'h0001; m_samp = 16'h00FF;
    m_cc1 = 16'h0; m_cc2 = 16'h0; m_stat = 16'h0020; m_chan = 4'd0; m_shut = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    check("R2 irq", 16'(irq), 16'h0);
    check("R2 shutdown", 16'(shutdown), 16'h0);
    check("R2 err", 16'(acc_err), 16'h0);
    check("R2 chan", 16'(adc_chan), 16'h0);
    rd_check("R2 mask", 5'h02);
    rd_check("R2 pending", 5'h01);
    rd_check("R2 status", 5'h16);
    rd_check("R2 cal", 5'h06);
    rd_check("R2 sample", 5'h09);
    rd_check("R2 cc1", 5'h0D);
    rd_check("R2 cc2", 5'h0E);

    // R1 identity, both strap values, write ignored
    rd_check("R1 id variant0", 5'h00);
    check("R1 id value", last_rd, 16'h0215);
    variant = 1'b1;
    wr_reg(5'h00, 16'hFFFF);
    rd_check("R1 id variant1", 5'h00);
    check("R1 id value", last_rd, 16'h0295);
    variant = 1'b0;

    // R3 XOR pending, R4 mask/irq
    wr_reg(5'h01, 16'hA005);
    rd_check("R3 xor set", 5'h01);
    check_irq("R4 all masked");
    wr_reg(5'h02, 16'hFFFB);
    check_irq("R4 unmask bit2");
    check("R4 irq high", 16'(irq), 16'h1);
    wr_reg(5'h01, 16'h0004);
    check("R4 irq after toggle clear", 16'(irq), 16'h0);
    rd_check("R3 xor clear", 5'h01);

    // R5 ADC channel and sample-done
    wr_reg(5'h02, 16'hFEFF);
    wr_reg(5'h08, 16'hC000 | (16'd11 << 10) | 16'h03FF);
    check("R5 chan out", 16'(adc_chan), 16'd11);
    check("R5 irq from sample", 16'(irq), 16'h1);
    rd_check("R5 adc read", 5'h08);
    rd_check("R5 pending bit8", 5'h01);

    // R6 sample clear
    wr_reg(5'h09, 16'h0011);
    rd_check("R6 clear bits", 5'h09);
    check("R6 value", last_rd, 16'h00EE);
    wr_reg(5'h09, 16'h0000);
    rd_check("R6 zero write", 5'h09);

    // R8 key edges, hold, edge concurrent with pending write
    wr_reg(5'h01, m_pend);
    set_key(1'b1);
    rd_check("R8 press pending", 5'h01);
    rd_check("R8 press status", 5'h16);
    wr_reg(5'h01, 16'h0001);
    repeat (5) @(negedge clk);
    rd_check("R8 hold no reset", 5'h01);
    // release edge on the same clock as a pending toggle of bit 0
    @(negedge clk);
    pwr_key = 1'b0;
    acc_valid = 1'b1; acc_dev = 3'd1; acc_write = 1'b1; acc_reg = 5'h01; acc_wdata = 16'h0001;
    @(negedge clk);
    acc_valid = 1'b0;
    m_pend = m_pend ^ 16'h0001; m_pend[0] = 1'b1; m_stat[5] = 1'b1;
    rd_check("R8 edge beats toggle", 5'h01);
    rd_check("R8 release status", 5'h16);

    // R9 plain registers
    wr_reg(5'h06, 16'h5AA5); rd_check("R9 cal", 5'h06);
    wr_reg(5'h0E, 16'h1234); rd_check("R9 cc2", 5'h0E);
    wr_reg(5'h0D, 16'hFFFD); rd_check("R9 cc1", 5'h0D);

    // R7 watchdog ordering
    wr_reg(5'h17, 16'h0000);
    check("R7 gated off", 16'(shutdown), 16'h0);
    wr_reg(5'h0D, 16'h0002);
    wr_reg(5'h17, 16'h0100);
    check("R7 nonzero", 16'(shutdown), 16'h0);
    rd_check("R7 reads zero", 5'h17);
    wr_reg(5'h17, 16'h0000);
    check("R7 shutdown", 16'(shutdown), 16'h1);
    wr_reg(5'h0D, 16'h0000);
    check("R7 sticky", 16'(shutdown), 16'h1);

    // R10 reserved addresses
    bus_access(3'd1, 1'b1, 5'h07, 16'hFFFF);
    check("R10 err write", 16'(last_err), 16'h1);
    bus_access(3'd1, 1'b0, 5'h13, 16'h0);
    check("R10 err read", 16'(last_err), 16'h1);
    check("R10 read zero", last_rd, 16'h0);
    @(negedge clk);
    check("R10 err single pulse", 16'(acc_err), 16'h0);
    rd_check("R10 no change", 5'h0D);

    // R11 foreign device
    rd_check("R11 prime", 5'h06);
    bus_access(3'd2, 1'b0, 5'h02, 16'h0);
    check("R11 rdata held", last_rd, m_cal);
    bus_access(3'd5, 1'b1, 5'h02, 16'h0000);
    check("R11 no err", 16'(last_err), 16'h0);
    rd_check("R11 mask unchanged", 5'h02);

    // R12 stub registers
    wr_reg(5'h0A, 16'hBEEF); rd_check("R12 stub 0a", 5'h0A);
    wr_reg(5'h1F, 16'hBEEF); rd_check("R12 stub 1f", 5'h1F);
    rd_check("R12 stub 04", 5'h04);

    // Random phase
    for (int i = 0; i < 1500; i++) begin
      int unsigned op = $urandom_range(0, 9);
      logic [4:0]  r  = 5'($urandom_range(0, 31));
      logic [15:0] d  = ($urandom_range(0, 3) == 0) ? 16'h0 : 16'($urandom);
      if (op < 4) begin
        bus_access(3'd1, 1'b1, r, d);
        check(is_reserved(r) ? "R10 rand err" : "R11 rand no err",
              16'(last_err), 16'(is_reserved(r)));
        model_write(r, d);
      end else if (op < 8) begin
        rd_check("R3 R5 R9 rand read", r);
      end else if (op == 8) begin
        set_key(~pwr_key);
      end else begin
        variant = ~variant;
        bus_access(3'($urandom_range(2, 7)), 1'($urandom), r, d);
        check("R11 rand foreign", 16'(last_err), 16'h0);
      end
      check_irq("R4 rand irq");
      check("R7 rand shutdown", 16'(shutdown), 16'(m_shut));
      check("R5 rand chan", 16'(adc_chan), 16'(m_chan));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule